// File: doc/BRIEF.md
# Paired-Bit Multi-Bank Block Interleaver

This block reorders one physical channel's frame of serial bits through one, two or three identical interleaver banks of 32 rows by 30 columns. The number of banks follows the modulation of the frame. With one bank a frame holds 960 bits. With two banks it holds 1920 bits, and with three banks 2880 bits. Incoming bits are handed out to the banks two at a time in rotation: bank 0, bank 1, then bank 2 when it is in use, and back to bank 0. Each bank is filled row by row. Its columns are then taken in a fixed permuted order and read top to bottom. The output is built from pairs taken from the banks in the same rotation.

The input and the output are valid/ready streams, one bit per beat. A beat moves only in a cycle where both valid and ready are high. While the sink holds `out_ready` low, `out_data` and `out_last` do not change. Two frame buffers let a new frame be written while the previous one is read out. `in_ready` drops only while both buffers hold complete frames that have not been fully read. The modulation select is sampled with the first bit of each frame. The frame ends after the number of bits that modulation implies. `in_last` is only compared against that count, and `frame_err` pulses when the two disagree.

Top module: `bank_pair_interleaver`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and `frame_err` is 0.
- R2: With one bank (`mod_sel` 0, or the reserved value 3) a frame is 960 bits. Output bit m = 32c + r (r in 0..31) equals input bit 30r + P[c], where P = 0,20,10,5,15,25,3,13,23,8,18,28,1,11,21,6,16,26,4,14,24,19,9,29,12,2,7,22,27,17.
- R3: With `mod_sel` 1 a frame is 1920 bits. Input bit k goes to bank (k/2) mod 2 at in-bank index 2·(k/4) + k mod 2. Output bit m comes from bank (m/2) mod 2 at in-bank output position 2·(m/4) + m mod 2. Each bank maps output position to input index as in R2.
- R4: With `mod_sel` 2 a frame is 2880 bits and uses three banks. Input bit k goes to bank (k/2) mod 3 at in-bank index 2·(k/6) + k mod 2. Output bit m comes from bank (m/2) mod 3 at position 2·(m/6) + m mod 2.
- R5: `mod_sel` is sampled only on the accepted first bit of a frame. Changes on later bits of that frame have no effect on its length or order.
- R6: `out_last` is 1 exactly on the final output bit of each frame.
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and `out_data` and `out_last` unchanged.
- R8: `in_ready` is 0 only while two complete frames are waiting or being read out. A new frame can be accepted while the previous frame is being read.
- R9: `frame_err` is 1 for one cycle after an accepted bit whose `in_last` differs from whether that bit is the frame's final bit by count. The frame is still delivered.
- R10: Frames leave in the order they arrived, and `out_valid` is 1 exactly while at least one complete frame is not yet fully read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_sel | input | 2 | Modulation: 0 one bank, 1 two banks, 2 three banks, 3 treated as 0 |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Block can take an input bit |
| in_data | input | 1 | Input bit |
| in_last | input | 1 | Source marks the final bit of its frame |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Sink takes the output bit |
| out_data | output | 1 | Output bit |
| out_last | output | 1 | Final bit of an output frame |
| frame_err | output | 1 | One-cycle pulse on a frame length mismatch |

## Verification
The hardest state to reach from the ports is both buffers holding complete frames, so that `in_ready` drops. The stimulus holds `out_ready` low and pushes two whole frames, then waits before the sink is released. Random `mod_sel` values on every non-first bit test that the sampled modulation stays fixed for the frame. A frame with `in_last` raised early and missing at its counted end produces two error pulses while the frame is still delivered intact.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    MOD_ONE   = 2'd0,
    MOD_TWO   = 2'd1,
    MOD_THREE = 2'd2,
    MOD_RSVD  = 2'd3
  } mod_e;

  // Banks in use for a modulation code; the reserved code behaves as one bank.
  function automatic int unsigned banks_for(logic [1:0] m);
    case (mod_e'(m))
      MOD_TWO:   return 2;
      MOD_THREE: return 3;
      default:   return 1;
    endcase
  endfunction

  // Source column read at output column slot c (30-column bank).
  function automatic int unsigned col_perm(int unsigned c);
    case (c)
      0: return 0;    1: return 20;   2: return 10;   3: return 5;
      4: return 15;   5: return 25;   6: return 3;    7: return 13;
      8: return 23;   9: return 8;    10: return 18;  11: return 28;
      12: return 1;   13: return 11;  14: return 21;  15: return 6;
      16: return 16;  17: return 26;  18: return 4;   19: return 14;
      20: return 24;  21: return 19;  22: return 9;   23: return 29;
      24: return 12;  25: return 2;   26: return 7;   27: return 22;
      28: return 27;  29: return 17;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/ilv_wr_seq.sv
module ilv_wr_seq
  import ilv_pkg::*;
#(
  parameter int ROWS = 32,
  parameter int COLS = 30,
  parameter int MAX_BANKS = 3,
  localparam int AW = $clog2(ROWS * COLS * MAX_BANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mod_i,
  input  logic          step,
  output logic [AW-1:0] waddr,
  output logic          final_bit,
  output logic [1:0]    mod_eff
);
  localparam int BANK_BITS = ROWS * COLS;
  localparam int BW = $clog2(MAX_BANKS + 1);
  localparam int PW = $clog2(BANK_BITS);

  logic [AW-1:0] cnt_q;
  logic          bit_q;
  logic [BW-1:0] bank_q;
  logic [PW-1:0] pos_q;
  logic [1:0]    mod_q;
  logic [BW-1:0] nb;
  logic [AW-1:0] last_idx;

  always_comb begin
    mod_eff   = (cnt_q == '0) ? mod_i : mod_q;
    nb        = BW'(banks_for(mod_eff));
    last_idx  = AW'(banks_for(mod_eff) * BANK_BITS - 1);
    final_bit = (cnt_q == last_idx);
    waddr     = AW'(bank_q) * AW'(BANK_BITS) + AW'(pos_q) + AW'(bit_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bit_q  <= 1'b0;
      bank_q <= '0;
      pos_q  <= '0;
      mod_q  <= '0;
    end else if (step) begin
      if (cnt_q == '0) mod_q <= mod_i;
      if (final_bit) begin
        cnt_q  <= '0;
        bit_q  <= 1'b0;
        bank_q <= '0;
        pos_q  <= '0;
      end else begin
        cnt_q <= cnt_q + AW'(1);
        if (!bit_q) begin
          bit_q <= 1'b1;
        end else begin
          bit_q <= 1'b0;
          if (bank_q == nb - BW'(1)) begin
            bank_q <= '0;
            pos_q  <= pos_q + PW'(2);
          end else begin
            bank_q <= bank_q + BW'(1);
          end
        end
      end
    end
  end

  // R5
  mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> $stable(mod_q));

  // R6
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (waddr <= last_idx));

endmodule

// File: rtl/ilv_rd_seq.sv
module ilv_rd_seq
  import ilv_pkg::*;
#(
  parameter int ROWS = 32,   // must be even: a pair never straddles a column
  parameter int COLS = 30,
  parameter int MAX_BANKS = 3,
  localparam int AW = $clog2(ROWS * COLS * MAX_BANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mod_i,
  input  logic          step,
  output logic [AW-1:0] raddr,
  output logic          final_bit
);
  localparam int BANK_BITS = ROWS * COLS;
  localparam int BW  = $clog2(MAX_BANKS + 1);
  localparam int RW  = $clog2(ROWS);
  localparam int CLW = $clog2(COLS);

  logic [AW-1:0]  cnt_q;
  logic           bit_q;
  logic [BW-1:0]  bank_q;
  logic [RW-1:0]  row_q;
  logic [CLW-1:0] col_q;
  logic [BW-1:0]  nb;
  logic [AW-1:0]  last_idx;

  always_comb begin
    nb        = BW'(banks_for(mod_i));
    last_idx  = AW'(banks_for(mod_i) * BANK_BITS - 1);
    final_bit = (cnt_q == last_idx);
    raddr     = AW'(bank_q) * AW'(BANK_BITS)
              + (AW'(row_q) + AW'(bit_q)) * AW'(COLS)
              + AW'(col_perm(32'(col_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bit_q  <= 1'b0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else if (step) begin
      if (final_bit) begin
        cnt_q  <= '0;
        bit_q  <= 1'b0;
        bank_q <= '0;
        row_q  <= '0;
        col_q  <= '0;
      end else begin
        cnt_q <= cnt_q + AW'(1);
        if (!bit_q) begin
          bit_q <= 1'b1;
        end else begin
          bit_q <= 1'b0;
          if (bank_q == nb - BW'(1)) begin
            bank_q <= '0;
            if (row_q == RW'(ROWS - 2)) begin
              row_q <= '0;
              col_q <= col_q + CLW'(1);
            end else begin
              row_q <= row_q + RW'(2);
            end
          end else begin
            bank_q <= bank_q + BW'(1);
          end
        end
      end
    end
  end

  // R2
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(col_q) < COLS);

  // R6
  rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == last_idx) |-> (bit_q && bank_q == nb - BW'(1)
                             && row_q == RW'(ROWS - 2) && 32'(col_q) == COLS - 1));

endmodule

// File: rtl/ilv_store.sv
module ilv_store #(
  parameter int NBUF  = 2,
  parameter int DEPTH = 2880,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [SW-1:0] rsel,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  logic rd_bit [NBUF];

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    logic [DEPTH-1:0] bits_q;
    always_ff @(posedge clk) begin
      if (we && wsel == SW'(g)) bits_q[waddr] <= wdata;
    end
    assign rd_bit[g] = bits_q[raddr];
  end

  assign rdata = rd_bit[rsel];

endmodule

// File: rtl/bank_pair_interleaver.sv
module bank_pair_interleaver
  import ilv_pkg::*;
#(
  parameter int ROWS = 32,
  parameter int COLS = 30,
  parameter int MAX_BANKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mod_sel,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_data,
  input  logic       in_last,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_data,
  output logic       out_last,
  output logic       frame_err
);
  localparam int DEPTH = ROWS * COLS * MAX_BANKS;
  localparam int AW = $clog2(DEPTH);

  logic [1:0]    full_q;
  logic          wsel_q, rsel_q;
  logic [1:0]    bmod_q [2];
  logic          err_q;
  logic          wr_step, rd_step;
  logic [AW-1:0] waddr, raddr;
  logic          w_final, r_final;
  logic [1:0]    w_mod;

  assign in_ready  = !full_q[wsel_q];
  assign out_valid = full_q[rsel_q];
  assign wr_step   = in_valid && in_ready;
  assign rd_step   = out_valid && out_ready;
  assign out_last  = r_final;
  assign frame_err = err_q;

  ilv_wr_seq #(.ROWS(ROWS), .COLS(COLS), .MAX_BANKS(MAX_BANKS)) u_wr (
    .clk(clk), .rst_n(rst_n), .mod_i(mod_sel), .step(wr_step),
    .waddr(waddr), .final_bit(w_final), .mod_eff(w_mod)
  );

  ilv_rd_seq #(.ROWS(ROWS), .COLS(COLS), .MAX_BANKS(MAX_BANKS)) u_rd (
    .clk(clk), .rst_n(rst_n), .mod_i(bmod_q[rsel_q]), .step(rd_step),
    .raddr(raddr), .final_bit(r_final)
  );

  ilv_store #(.NBUF(2), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(wr_step), .wsel(wsel_q), .waddr(waddr), .wdata(in_data),
    .rsel(rsel_q), .raddr(raddr), .rdata(out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q    <= '0;
      wsel_q    <= 1'b0;
      rsel_q    <= 1'b0;
      bmod_q[0] <= '0;
      bmod_q[1] <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q <= wr_step && (in_last != w_final);
      if (wr_step && w_final) begin
        full_q[wsel_q] <= 1'b1;
        bmod_q[wsel_q] <= w_mod;
        wsel_q         <= ~wsel_q;
      end
      if (rd_step && r_final) begin
        full_q[rsel_q] <= 1'b0;
        rsel_q         <= ~rsel_q;
      end
    end
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R8
  stall_has_reader_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);

  // R9
  err_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(in_valid && in_ready));

  // R10
  frame_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (rsel_q != $past(rsel_q)));

endmodule

// File: tb/tb_bank_pair_interleaver.sv
module tb_bank_pair_interleaver;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic [1:0] mod_sel;
  logic       in_valid, in_ready, in_data, in_last;
  logic       out_valid, out_ready, out_data, out_last;
  logic       frame_err;

  bank_pair_interleaver dut (
    .clk(clk), .rst_n(rst_n), .mod_sel(mod_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .frame_err(frame_err)
  );

  int checks = 0;
  int fails = 0;
  int perm_t [30] = '{0,20,10,5,15,25,3,13,23,8,18,28,1,11,21,6,16,26,4,14,24,19,9,29,12,2,7,22,27,17};
  int cur [$];
  int fmod = 0;
  int exp_bit [$];
  int exp_last [$];
  int exp_mod [$];
  int pending = 0;
  bit err_pend = 0;
  bit prev_stall = 0;
  bit prev_data = 0;
  bit prev_last = 0;
  bit mon_on = 0;
  int rdy_mode = 0;
  int cyc = 0;

  function automatic int nb_of(int m);
    return (m == 1) ? 2 : ((m == 2) ? 3 : 1);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Expected output order from the bank rotation and column permutation rules.
  function automatic void build(int m);
    int nb = nb_of(m);
    int n = nb * 960;
    for (int i = 0; i < n; i++) begin
      int b = (i / 2) % nb;
      int q = (i / (2 * nb)) * 2 + i % 2;
      int c = q / 32;
      int r = q % 32;
      int j = r * 30 + perm_t[c];
      int k = (j / 2) * 2 * nb + b * 2 + j % 2;
      exp_bit.push_back(cur[k]);
      exp_last.push_back((i == n - 1) ? 1 : 0);
      exp_mod.push_back(m);
    end
  endfunction

  always @(posedge clk) begin
    #2;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'($urandom_range(0, 1));
      default: out_ready = 1'b0;
    endcase
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R10 watchdog expired: actual %0d expected %0d", pending, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin : mon
    int eb, el, em;
    bit fin;
    string tag;
    if (mon_on) begin
      check(frame_err == err_pend, "R9", "frame_err", frame_err, err_pend);
      check(in_ready == (pending < 2), "R8", "in_ready", in_ready, pending < 2);
      check(out_valid == (pending > 0), "R10", "out_valid", out_valid, pending > 0);
      if (prev_stall)
        check(out_valid && out_data == prev_data && out_last == prev_last, "R7",
              "held output", {out_valid, out_data, out_last}, {1'b1, prev_data, prev_last});
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
      err_pend   = 0;
      if (out_valid && out_ready) begin
        if (exp_bit.size() == 0) begin
          check(0, "R10", "unexpected output bit", 1, 0);
        end else begin
          eb = exp_bit.pop_front();
          el = exp_last.pop_front();
          em = exp_mod.pop_front();
          tag = (em == 1) ? "R3/R5" : ((em == 2) ? "R4/R5" : "R2/R5");
          check(out_data == eb, tag, "out_data", out_data, eb);
          check(out_last == el, "R6", "out_last", out_last, el);
          if (el == 1) pending--;
        end
      end
      if (in_valid && in_ready) begin
        if (cur.size() == 0) fmod = mod_sel;
        cur.push_back(in_data);
        fin = (cur.size() == nb_of(fmod) * 960);
        err_pend = (in_last != fin);
        if (fin) begin
          build(fmod);
          cur.delete();
          pending++;
        end
      end
    end
  end

  task automatic send_frame(int m, int bad_at);
    int n = nb_of(m) * 960;
    bit acc;
    for (int k = 0; k < n; k++) begin
      mod_sel  = (k == 0) ? 2'(m) : 2'($urandom_range(0, 3));
      in_valid = 1'b1;
      in_data  = 1'($urandom_range(0, 1));
      in_last  = (bad_at >= 0) ? (k == bad_at) : (k == n - 1);
      do begin
        @(negedge clk);
        acc = in_ready;
        @(posedge clk);
        #2;
      end while (!acc);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_drain();
    while (pending > 0) @(posedge clk);
    repeat (4) @(posedge clk);
    #2;
  endtask

  initial begin
    rst_n = 1'b0;
    mod_sel = 2'd0;
    in_valid = 1'b0;
    in_data = 1'b0;
    in_last = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(frame_err == 1'b0, "R1", "frame_err in reset", frame_err, 0);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R2, R3, R4, R5: each modulation with random sink stalls
    rdy_mode = 1;
    send_frame(0, -1);
    send_frame(1, -1);
    send_frame(2, -1);
    rdy_mode = 0;
    wait_drain();

    // R8: sink stopped, two frames fill both buffers
    rdy_mode = 2;
    send_frame(0, -1);
    send_frame(3, -1);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R8", "in_ready with both buffers full", in_ready, 0);
    check(out_valid == 1'b1, "R8", "out_valid with both buffers full", out_valid, 1);
    @(posedge clk);
    #2;

    // R9: early last and missing last; frame still delivered
    rdy_mode = 1;
    send_frame(0, 100);
    send_frame(1, -1);
    send_frame(2, -1);
    rdy_mode = 0;
    wait_drain();
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "idle after drain", out_valid, 0);
    check(exp_bit.size() == 0, "R10", "leftover expected bits", exp_bit.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule